// File: doc/BRIEF.md
# Register-Mapped Random Word Generator

This block is a small bus slave that hands out 32-bit random words to software. A linear feedback shift register stands in for an entropy source. While generation is enabled, it produces a word every few cycles and places it in a four-entry output queue. Software polls a ready bit or waits for the interrupt, then reads the data register to pop one word.

Two external fault inputs let a testbench or a monitor inject problems. A clock fault raises a clock-error state bit and a sticky flag, unless detection of that fault is switched off. A seed fault halts generation and drops every queued word. Once the fault has gone, software must do two things before fresh words appear again: clear the seed flag, and make twelve discarded data reads to flush the pipeline.

A four-state controller sequences the block:
- OFF is idle with the queue empty.
- RUN generates words.
- HALT is seed error present.
- FLUSH waits for the discard reads.

Its transitions are:
- OFF to RUN, on enable.
- Any state to OFF, on disable.
- RUN or FLUSH to HALT, on seed fault.
- HALT to FLUSH, when the fault is gone.
- FLUSH to RUN, when twelve reads have been counted and the seed flag is clear.

Top module: `rng_periph`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, `irq_o` is low and `bus_rd_data` is 0.
- R2: The control register at offset 0x0 holds three bits: bit 2 = generation enable, bit 3 = interrupt enable, bit 5 = clock-fault detection off. All other bits read as 0.
- R3: While the block is enabled and free of seed error, it pushes a new non-zero word every 8 cycles while the 4-entry queue has room. Status bit 0 (ready) is 1 while the queue holds at least one word. Successive words differ.
- R4: A read of the data register at offset 0x8 pops the oldest word, one cycle after `bus_rd_en`. A data read with an empty queue returns 0, and ready stays 0.
- R5: A seed fault (`seed_fault_i` high) in RUN or FLUSH empties the queue and stops generation. While the fault lasts, status bit 2 reads 1. Status bit 6 (seed flag) is set.
- R6: The seed flag at status bit 6 (offset 0x4) stays set until software writes the status register with bit 6 = 0. Writing 1 there has no effect.
- R7: After the seed fault is gone, data reads return 0 and no word becomes ready until 12 data reads have been made and the seed flag is clear. Generation then resumes.
- R8: When control bit 5 is 0, status bit 1 follows `clk_fault_i` one cycle later, and status bit 5 (clock flag) is set and stays set until a status write with bit 5 = 0. When control bit 5 is 1, neither status bit rises.
- R9: `irq_o` is high exactly when the interrupt enable is set and any of these is 1: ready, the clock flag, or the seed flag.
- R10: Writing 0 to the control register stops generation and empties the queue. A later enable returns the block to normal generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, data valid next cycle |
| bus_rd_data | output | 32 | Registered read data |
| seed_fault_i | input | 1 | Injected noise-source fault |
| clk_fault_i | input | 1 | Injected clock fault |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drains the queue with four back-to-back reads and then reads once more at once. A design that refilled from a free-running tick, or popped a phantom word, would show ready or return non-zero data there.

Seed recovery is tested in both orders. In one, the flag is cleared before the twelve discard reads. In the other, the flag is left set past the twelfth read. A design that counted eleven reads, or ignored the flag, would show ready too early. A design that needed a fault-free status write after the reads would never resume.

The clock fault is injected with detection on and with detection off, which catches a design that tied the flag to the raw input. The bench also checks that writing a 1 to a flag leaves that flag as it was.

// File: rtl/rng_pkg.sv
package rng_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_FLUSH = 2'd3
    } rng_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_DATA = 8'h08;

    localparam int CB_EN  = 2;
    localparam int CB_IE  = 3;
    localparam int CB_CED = 5;

    localparam int SB_RDY  = 0;
    localparam int SB_CLKS = 1;
    localparam int SB_SEDS = 2;
    localparam int SB_CLKF = 5;
    localparam int SB_SEDF = 6;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [31:0] value
);
    logic [31:0] sr;
    logic        fb;

    // taps for x^32 + x^22 + x^2 + x + 1
    assign fb = sr[31] ^ sr[21] ^ sr[1] ^ sr[0];

    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= SEED;
        else if (step)  sr <= {sr[30:0], fb};
    end

    assign value = sr;
endmodule

// File: rtl/rng_queue.sv
module rng_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wp] <= din;
    end
endmodule

// File: rtl/rng_periph.sv
module rng_periph #(
    parameter int          ADDR_W      = 4,
    parameter int          QDEPTH      = 4,
    parameter int          GEN_PERIOD  = 8,
    parameter int          FLUSH_READS = 12,
    parameter logic [31:0] LFSR_SEED   = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rd_data,
    input  logic              seed_fault_i,
    input  logic              clk_fault_i,
    output logic              irq_o
);
    import rng_pkg::*;

    localparam int GW = (GEN_PERIOD > 1) ? $clog2(GEN_PERIOD) : 1;
    localparam int FW = $clog2(FLUSH_READS + 1);
    localparam logic [GW-1:0] GEN_LAST  = GW'(GEN_PERIOD - 1);
    localparam logic [FW-1:0] FLUSH_END = FW'(FLUSH_READS);

    rng_state_e state, nxt;

    logic ctrl_en, ctrl_ie, ctrl_ced;
    logic seed_flag, clk_flag, clk_now;
    logic [GW-1:0] gen_cnt;
    logic [FW-1:0] flush_cnt;

    logic sel_ctrl, sel_stat, sel_data;
    logic gen_run, q_clear, seed_now, seed_set, flush_done;
    logic q_push, q_pop, q_empty, q_full;
    logic [31:0] lfsr_val, q_head, stat_word;

    assign sel_ctrl = (bus_addr == OFS_CTRL[ADDR_W-1:0]);
    assign sel_stat = (bus_addr == OFS_STAT[ADDR_W-1:0]);
    assign sel_data = (bus_addr == OFS_DATA[ADDR_W-1:0]);

    assign flush_done = (flush_cnt == FLUSH_END);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (ctrl_en) nxt = ST_RUN;
            ST_RUN:   if (!ctrl_en) nxt = ST_OFF;
                      else if (seed_fault_i) nxt = ST_HALT;
            ST_HALT:  if (!ctrl_en) nxt = ST_OFF;
                      else if (!seed_fault_i) nxt = ST_FLUSH;
            ST_FLUSH: if (!ctrl_en) nxt = ST_OFF;
                      else if (seed_fault_i) nxt = ST_HALT;
                      else if (flush_done && !seed_flag) nxt = ST_RUN;
            default:  nxt = ST_OFF;
        endcase
    end

    // per-state outputs
    always_comb begin
        gen_run  = 1'b0;
        q_clear  = 1'b0;
        seed_now = 1'b0;
        unique case (state)
            ST_OFF:   q_clear = 1'b1;
            ST_RUN:   gen_run = 1'b1;
            ST_HALT:  begin q_clear = 1'b1; seed_now = 1'b1; end
            ST_FLUSH: ;
            default:  q_clear = 1'b1;
        endcase
        seed_set = (state != ST_HALT) && (nxt == ST_HALT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_ie  <= 1'b0;
            ctrl_ced <= 1'b0;
        end else if (bus_wr_en && sel_ctrl) begin
            ctrl_en  <= bus_wr_data[CB_EN];
            ctrl_ie  <= bus_wr_data[CB_IE];
            ctrl_ced <= bus_wr_data[CB_CED];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_flag <= 1'b0;
            clk_flag  <= 1'b0;
            clk_now   <= 1'b0;
        end else begin
            clk_now <= clk_fault_i && !ctrl_ced;
            if (seed_set)
                seed_flag <= 1'b1;
            else if (bus_wr_en && sel_stat && !bus_wr_data[SB_SEDF])
                seed_flag <= 1'b0;
            if (clk_fault_i && !ctrl_ced)
                clk_flag <= 1'b1;
            else if (bus_wr_en && sel_stat && !bus_wr_data[SB_CLKF])
                clk_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !gen_run)  gen_cnt <= '0;
        else if (!q_full)        gen_cnt <= (gen_cnt == GEN_LAST) ? '0 : gen_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_FLUSH)
            flush_cnt <= '0;
        else if (bus_rd_en && sel_data && !flush_done)
            flush_cnt <= flush_cnt + 1'b1;
    end

    assign q_push = gen_run && !q_full && (gen_cnt == GEN_LAST);
    assign q_pop  = bus_rd_en && sel_data && gen_run && !q_empty;

    rng_lfsr #(.SEED(LFSR_SEED)) u_src (
        .clk(clk), .rst_n(rst_n), .step(gen_run), .value(lfsr_val)
    );

    rng_queue #(.W(32), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .clear(q_clear),
        .push(q_push), .din(lfsr_val), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    always_comb begin
        stat_word          = '0;
        stat_word[SB_RDY]  = !q_empty;
        stat_word[SB_CLKS] = clk_now;
        stat_word[SB_SEDS] = seed_now;
        stat_word[SB_CLKF] = clk_flag;
        stat_word[SB_SEDF] = seed_flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd_data <= '0;
        end else if (bus_rd_en) begin
            bus_rd_data <= '0;
            if (sel_ctrl) begin
                bus_rd_data[CB_EN]  <= ctrl_en;
                bus_rd_data[CB_IE]  <= ctrl_ie;
                bus_rd_data[CB_CED] <= ctrl_ced;
            end else if (sel_stat) begin
                bus_rd_data <= stat_word;
            end else if (sel_data && q_pop) begin
                bus_rd_data <= q_head;
            end
        end
    end

    assign irq_o = ctrl_ie && (!q_empty || seed_flag || clk_flag);
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [31:0]       bus_wr_data,
    input logic              bus_rd_en,
    input logic [31:0]       bus_rd_data,
    input logic              irq_o,
    input logic [1:0]        state,
    input logic              ctrl_ie,
    input logic              seed_flag,
    input logic              q_push,
    input logic              q_full,
    input logic              q_empty
);
    import rng_pkg::*;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_push);

    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFS_DATA[ADDR_W-1:0] && q_empty) |=> (bus_rd_data == 32'd0));

    a_r5_halt_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_HALT)) |-> !q_push);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_flag && !(bus_wr_en && bus_addr == OFS_STAT[ADDR_W-1:0] && !bus_wr_data[SB_SEDF]))
        |=> seed_flag);

    a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_FLUSH)) |-> q_empty);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_ie |-> !irq_o);

    a_r9_irq_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ie && seed_flag) |-> irq_o);

    a_r10_off_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_OFF)) |=> q_empty);
endmodule

bind rng_periph rng_periph_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .irq_o(irq_o), .state(state), .ctrl_ie(ctrl_ie), .seed_flag(seed_flag),
    .q_push(q_push), .q_full(q_full), .q_empty(q_empty)
);

// File: tb/rng_periph_tb_top.sv
`timescale 1ns/1ps
module rng_periph_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rd_data;
    logic        seed_fault_i = 1'b0;
    logic        clk_fault_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_DATA = 4'h8;

    always #2.5 clk = ~clk;

    rng_periph dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .seed_fault_i(seed_fault_i), .clk_fault_i(clk_fault_i), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_true(input string tag, input bit cond);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual 0 expected 1", tag);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 rd_data", bus_rd_data, 32'd0);
        bus_rd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
        bus_rd(A_STAT, d); chk("R1 stat", d, 32'd0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'hFFFF_FFFF);
        bus_rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h2C);
        bus_wr(A_CTRL, 32'h0);
        idle(3);
        bus_rd(A_CTRL, d); chk("R2 ctrl cleared", d, 32'h0);
    endtask

    task automatic t_generate;
        logic [31:0] d, w[4];
        bus_rd(A_DATA, d); chk("R4 empty read off", d, 32'h0);
        bus_wr(A_CTRL, 32'h4);
        idle(60);
        bus_rd(A_STAT, d); chk("R3 ready when filled", d, 32'h1);
        for (int i = 0; i < 4; i++) bus_rd(A_DATA, w[i]);
        bus_rd(A_STAT, d); chk("R3 depth four, ready low after drain", d, 32'h0);
        bus_rd(A_DATA, d); chk("R4 empty read returns zero", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            chk_true("R3 word nonzero", w[i] != 32'h0);
            for (int j = i + 1; j < 4; j++) chk_true("R3 words differ", w[i] != w[j]);
        end
        idle(20);
        bus_rd(A_STAT, d); chk("R3 refill after drain", d, 32'h1);
    endtask

    task automatic t_seed_clear_first;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_CTRL, 32'hC);
        idle(60);
        seed_fault_i = 1'b1;
        idle(3);
        bus_rd(A_STAT, d); chk("R5 seed state and flag", d, 32'h44);
        chk("R9 irq on seed flag", {31'd0, irq_o}, 32'd1);
        idle(40);
        bus_rd(A_STAT, d); chk("R5 no generation in fault", d, 32'h44);
        seed_fault_i = 1'b0;
        idle(2);
        bus_rd(A_STAT, d); chk("R6 flag sticky after fault", d, 32'h40);
        bus_wr(A_STAT, 32'h40);
        bus_rd(A_STAT, d); chk("R6 write one ignored", d, 32'h40);
        bus_wr(A_STAT, 32'h0);
        bus_rd(A_STAT, d); chk("R6 write zero clears", d, 32'h0);
        chk("R9 irq low", {31'd0, irq_o}, 32'd0);
        for (int i = 0; i < 11; i++) begin
            bus_rd(A_DATA, d); chk("R7 discard read zero", d, 32'h0);
        end
        idle(40);
        bus_rd(A_STAT, d); chk("R7 not ready after 11 reads", d, 32'h0);
        bus_rd(A_DATA, d); chk("R7 twelfth read zero", d, 32'h0);
        idle(40);
        bus_rd(A_STAT, d); chk("R7 resumes after 12 reads", d, 32'h1);
        chk("R9 irq on ready", {31'd0, irq_o}, 32'd1);
    endtask

    task automatic t_seed_flag_late;
        logic [31:0] d;
        seed_fault_i = 1'b1;
        idle(2);
        seed_fault_i = 1'b0;
        idle(2);
        for (int i = 0; i < 12; i++) bus_rd(A_DATA, d);
        idle(40);
        bus_rd(A_STAT, d); chk("R7 flag set blocks resume", d, 32'h40);
        bus_wr(A_STAT, 32'h0);
        idle(40);
        bus_rd(A_STAT, d); chk("R7 resume after late clear", d, 32'h1);
    endtask

    task automatic t_clock_fault;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'h0);
        idle(3);
        clk_fault_i = 1'b1;
        idle(2);
        bus_rd(A_STAT, d); chk("R8 clock state and flag", d, 32'h22);
        clk_fault_i = 1'b0;
        idle(2);
        bus_rd(A_STAT, d); chk("R8 clock flag sticky", d, 32'h20);
        bus_wr(A_STAT, 32'h0);
        bus_rd(A_STAT, d); chk("R8 clock flag cleared", d, 32'h0);
        bus_wr(A_CTRL, 32'h20);
        clk_fault_i = 1'b1;
        idle(3);
        bus_rd(A_STAT, d); chk("R8 detection off", d, 32'h0);
        clk_fault_i = 1'b0;
        bus_wr(A_CTRL, 32'h8);
        chk("R9 irq idle", {31'd0, irq_o}, 32'd0);
        clk_fault_i = 1'b1;
        idle(2);
        clk_fault_i = 1'b0;
        chk("R9 irq on clock flag", {31'd0, irq_o}, 32'd1);
        bus_wr(A_STAT, 32'h0);
        chk("R9 irq after clear", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'h4);
        idle(60);
        bus_wr(A_CTRL, 32'h0);
        idle(3);
        bus_rd(A_STAT, d); chk("R10 disable drains", d, 32'h0);
        bus_rd(A_DATA, d); chk("R10 data zero when off", d, 32'h0);
        idle(40);
        bus_rd(A_STAT, d); chk("R10 stays idle", d, 32'h0);
        bus_wr(A_CTRL, 32'h4);
        idle(60);
        bus_rd(A_STAT, d); chk("R10 restart generates", d, 32'h1);
        bus_rd(A_DATA, d); chk_true("R10 restart word nonzero", d != 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ctrl();
        t_generate();
        t_seed_clear_first();
        t_seed_flag_late();
        t_clock_fault();
        t_restart();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule